// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Output Timing

This block is a first-in first-out buffer that joins two unrelated clock domains. A producer pushes 18-bit words on the write clock and a consumer drains them on the read clock. Both enables are active low. The storage depth is a parameter and may be 256, 512, 1024, 2048 or 4096 words. The write and read pointers cross between the domains as Gray codes through two-flop synchronisers. The full flag is formed on the write side and the data-available flag is formed on the read side.

A three-bit configuration input is sampled while reset is held, and it selects one of two output behaviours. In request mode the output register changes only when a read is accepted. The read-side flag then means "not empty". In fall-through mode the oldest word is moved into the output register without any request. The same flag then means "the output register holds a valid word", and an accepted read consumes that word.

Top module: `xclk_fifo`

## Requirements
- R1: Output mode is decoded from `mode_cfg` on each `rd_clk` rising edge while `rst_n` is low, and is then held until the next reset. `mode_cfg[1:0]` = 2'b01 selects fall-through mode. Every other value, including 2'b10, 2'b00 and 2'b11, selects request mode. `mode_cfg[2]` is ignored.
- R2: After reset, `q` is zero, `rd_flag` is low and `wr_full` is low, and both pointers start at zero.
- R3: After DEPTH accepted writes with no reads, `wr_full` is high. A write attempted while `wr_full` is high stores nothing and does not move the write pointer.
- R4: Words leave in the order they were written, with all 18 bits intact. Each pointer's Gray code changes in at most one bit per clock of its own domain.
- R5: In request mode, `rd_flag` rises no later than the fourth `rd_clk` rising edge after the write edge that fills an empty FIFO. It may be one edge later when the two clock edges nearly coincide. It falls on the same edge that accepts the read of the last stored word.
- R6: In request mode, a write does not change `q`. A read (`rd_en_n` low while `rd_flag` is high) loads the oldest word into `q` on that `rd_clk` edge.
- R7: In request mode, a read attempted while `rd_flag` is low leaves `q` and `rd_flag` unchanged.
- R8: In fall-through mode, the first word written into an empty FIFO appears on `q` with `rd_flag` high, with no read, within five `rd_clk` rising edges of the write.
- R9: In fall-through mode, a read while `rd_flag` is high consumes the word on `q`, and on the same edge loads the next stored word if there is one. When the last word is consumed, `rd_flag` drops and `q` keeps that last word.
- R10: In fall-through mode, a read attempted while `rd_flag` is low leaves `q` unchanged.
- R11: After a full FIFO is drained, `wr_full` returns low within a few `wr_clk` cycles. The words that were refused while full never appear on the read side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Active-low reset for both domains; mode is sampled while low |
| mode_cfg | input | 3 | Output-mode configuration, sampled during reset |
| wr_en_n | input | 1 | Active-low write request |
| wr_data | input | DW | Word to store |
| wr_full | output | 1 | High when no free entry remains |
| rd_en_n | input | 1 | Active-low read request |
| q | output | DW | Output data register |
| rd_flag | output | 1 | Not-empty (request mode) or output-valid (fall-through mode) |

## Verification
The bench fills the FIFO to exactly DEPTH words and then keeps pushing. A design that wrapped the write pointer would overwrite the oldest data, or show words on the read side that were refused while full. It drains the FIFO completely in both modes and then issues reads into the empty state. An off-by-one in the empty comparison would return a stale word or change `q`. For fall-through mode it confirms three things: the first word shows up with no request, the last consumed word stays on `q` as `rd_flag` drops, and changing `mode_cfg` after reset has no effect. Undefined encodings are checked to fall back to request mode, so a decoder that read the wrong bit would show fall-through data without a read.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;

    localparam int WORD_W = 18;

    typedef enum logic {
        MODE_REQ  = 1'b0,
        MODE_FALL = 1'b1
    } rd_mode_e;

    // Only the low two bits choose; bit 2 carries no meaning.
    function automatic rd_mode_e decode_mode(input logic [2:0] cfg);
        return (cfg[1:0] == 2'b01) ? MODE_FALL : MODE_REQ;
    endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.meta   = din;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.stable;
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
    parameter int AW = 8,
    parameter int DW = 18
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int ENTRIES = 1 << AW;

    logic [DW-1:0] store [ENTRIES];

    always_ff @(posedge wr_clk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl #(
    parameter int AW = 8
) (
    input  logic          wr_clk,
    input  logic          rst_n,
    input  logic          wr_en_n,
    input  logic [AW:0]   rgray_sync,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [AW:0]   wbin,
    output logic [AW:0]   wgray,
    output logic          wr_full
);
    localparam int PW = AW + 1;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          full;
    } wst_t;

    wst_t st_d, st_q;
    logic push;
    logic [PW-1:0] full_pattern;

    function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    always_comb begin
        push         = !wr_en_n && !st_q.full;
        // Full when the write pointer is one lap ahead of the read pointer:
        // in Gray code the two top bits are inverted, the rest equal.
        full_pattern = {~rgray_sync[AW:AW-1], rgray_sync[AW-2:0]};
        st_d         = st_q;
        st_d.bin     = st_q.bin + {{AW{1'b0}}, push};
        st_d.gray    = to_gray(st_d.bin);
        st_d.full    = (st_d.gray == full_pattern);
    end

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_we    = push;
    assign mem_waddr = st_q.bin[AW-1:0];
    assign wbin      = st_q.bin;
    assign wgray     = st_q.gray;
    assign wr_full   = st_q.full;
endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl
    import xfifo_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 18
) (
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic [2:0]    mode_cfg,
    input  logic          rd_en_n,
    input  logic [AW:0]   wgray_sync,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_raddr,
    output logic [AW:0]   rbin,
    output logic [AW:0]   rgray,
    output logic [DW-1:0] q,
    output logic          rd_flag,
    output logic          fall_mode
);
    localparam int PW = AW + 1;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          empty;
        logic          ready;
        logic [DW-1:0] data;
    } rst_t;

    localparam rst_t RST_VAL = '{bin: '0, gray: '0, empty: 1'b1,
                                 ready: 1'b0, data: '0};

    rst_t     st_d, st_q;
    rd_mode_e mode_q;
    logic     take_req, load_fall, consume_fall, advance;

    function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    // Mode register follows the decoded configuration while reset is held.
    always_ff @(posedge rd_clk) begin
        if (!rst_n) mode_q <= decode_mode(mode_cfg);
    end

    always_comb begin
        take_req     = (mode_q == MODE_REQ) && !rd_en_n && !st_q.empty;
        consume_fall = (mode_q == MODE_FALL) && st_q.ready && !rd_en_n;
        load_fall    = (mode_q == MODE_FALL) && !st_q.empty
                       && (!st_q.ready || !rd_en_n);
        advance      = take_req || load_fall;

        st_d = st_q;
        if (advance) begin
            st_d.bin  = st_q.bin + {{AW{1'b0}}, 1'b1};
            st_d.data = mem_rdata;
        end
        st_d.gray  = to_gray(st_d.bin);
        // Registered from the next pointer so the flag drops on the very
        // edge that takes the last word.
        st_d.empty = (st_d.gray == wgray_sync);
        if (load_fall)         st_d.ready = 1'b1;
        else if (consume_fall) st_d.ready = 1'b0;
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_VAL;
        else        st_q <= st_d;
    end

    assign mem_raddr = st_q.bin[AW-1:0];
    assign rbin      = st_q.bin;
    assign rgray     = st_q.gray;
    assign q         = st_q.data;
    assign fall_mode = (mode_q == MODE_FALL);
    assign rd_flag   = fall_mode ? st_q.ready : !st_q.empty;
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo
    import xfifo_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int DW    = WORD_W
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic [2:0]    mode_cfg,
    input  logic          wr_en_n,
    input  logic [DW-1:0] wr_data,
    output logic          wr_full,
    input  logic          rd_en_n,
    output logic [DW-1:0] q,
    output logic          rd_flag
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic          mem_we;
    logic [AW-1:0] mem_waddr, mem_raddr;
    logic [DW-1:0] mem_rdata;
    logic [PW-1:0] wbin, wgray, rbin, rgray;
    logic [PW-1:0] wgray_sync, rgray_sync;
    logic          fall_mode;

    dcf_mem #(.AW(AW), .DW(DW)) mem_i (
        .wr_clk (wr_clk),
        .we     (mem_we),
        .waddr  (mem_waddr),
        .wdata  (wr_data),
        .raddr  (mem_raddr),
        .rdata  (mem_rdata)
    );

    dcf_wr_ctrl #(.AW(AW)) wr_i (
        .wr_clk     (wr_clk),
        .rst_n      (rst_n),
        .wr_en_n    (wr_en_n),
        .rgray_sync (rgray_sync),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .wbin       (wbin),
        .wgray      (wgray),
        .wr_full    (wr_full)
    );

    dcf_sync #(.W(PW)) r2w_i (
        .clk   (wr_clk),
        .rst_n (rst_n),
        .din   (rgray),
        .dout  (rgray_sync)
    );

    dcf_sync #(.W(PW)) w2r_i (
        .clk   (rd_clk),
        .rst_n (rst_n),
        .din   (wgray),
        .dout  (wgray_sync)
    );

    dcf_rd_ctrl #(.AW(AW), .DW(DW)) rd_i (
        .rd_clk     (rd_clk),
        .rst_n      (rst_n),
        .mode_cfg   (mode_cfg),
        .rd_en_n    (rd_en_n),
        .wgray_sync (wgray_sync),
        .mem_rdata  (mem_rdata),
        .mem_raddr  (mem_raddr),
        .rbin       (rbin),
        .rgray      (rgray),
        .q          (q),
        .rd_flag    (rd_flag),
        .fall_mode  (fall_mode)
    );
endmodule

// File: rtl/dcf_chk.sv
module dcf_chk #(
    parameter int DEPTH = 256,
    parameter int DW    = 18
) (
    input logic                       wr_clk,
    input logic                       rd_clk,
    input logic                       rst_n,
    input logic                       wr_en_n,
    input logic                       rd_en_n,
    input logic                       wr_full,
    input logic                       rd_flag,
    input logic [DW-1:0]              q,
    input logic [$clog2(DEPTH):0]     wbin,
    input logic [$clog2(DEPTH):0]     rbin,
    input logic [$clog2(DEPTH):0]     wgray,
    input logic [$clog2(DEPTH):0]     rgray,
    input logic                       fall_mode
);
    localparam int PW = $clog2(DEPTH) + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    logic [PW-1:0] fill;
    assign fill = wbin - rbin;

    // R3: a refused write leaves the write pointer where it was
    a_r3_full_refuses: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (wr_full && !wr_en_n) |=> (wbin == $past(wbin)));

    // R3: occupancy never exceeds the storage
    a_r3_no_overflow: assert property (@(posedge wr_clk) disable iff (!rst_n)
        fill <= DEPTH_P);

    // R4: Gray pointers change one bit at a time
    a_r4_wgray_step: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1);

    a_r4_rgray_step: assert property (@(posedge rd_clk) disable iff (!rst_n)
        $countones(rgray ^ $past(rgray)) <= 1);

    // R7: request mode, read on empty keeps the output
    a_r7_empty_read_holds: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (!fall_mode && !rd_flag && !rd_en_n) |=> $stable(q));

    // R9: fall-through valid drops only after a consuming read
    a_r9_drop_after_read: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (fall_mode && $fell(rd_flag)) |-> $past(!rd_en_n));
endmodule

bind xclk_fifo dcf_chk #(.DEPTH(DEPTH), .DW(DW)) chk_i (
    .wr_clk    (wr_clk),
    .rd_clk    (rd_clk),
    .rst_n     (rst_n),
    .wr_en_n   (wr_en_n),
    .rd_en_n   (rd_en_n),
    .wr_full   (wr_full),
    .rd_flag   (rd_flag),
    .q         (q),
    .wbin      (wbin),
    .rbin      (rbin),
    .wgray     (wgray),
    .rgray     (rgray),
    .fall_mode (fall_mode)
);

// File: tb/xclk_fifo_tb_top.sv
`timescale 1ns/100ps
module xclk_fifo_tb_top;
    localparam int DEPTH = 256;
    localparam int DW    = 18;

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          rst_n  = 1'b0;
    logic [2:0]    mode_cfg = 3'b010;
    logic          wr_en_n = 1'b1;
    logic [DW-1:0] wr_data = '0;
    logic          wr_full;
    logic          rd_en_n = 1'b1;
    logic [DW-1:0] q;
    logic          rd_flag;

    int checks = 0;
    int errors = 0;

    always #4   wr_clk = ~wr_clk;   // 125 MHz
    always #5.5 rd_clk = ~rd_clk;

    xclk_fifo #(.DEPTH(DEPTH), .DW(DW)) dut_i (
        .wr_clk   (wr_clk),
        .rd_clk   (rd_clk),
        .rst_n    (rst_n),
        .mode_cfg (mode_cfg),
        .wr_en_n  (wr_en_n),
        .wr_data  (wr_data),
        .wr_full  (wr_full),
        .rd_en_n  (rd_en_n),
        .q        (q),
        .rd_flag  (rd_flag)
    );

    function automatic logic [DW-1:0] word_of(input int i);
        return DW'(i * 37 + 5) ^ 18'h2A5A5;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [2:0] cfg);
        rst_n    = 1'b0;
        mode_cfg = cfg;
        wr_en_n  = 1'b1;
        rd_en_n  = 1'b1;
        repeat (5) @(negedge rd_clk);
        rst_n = 1'b1;
        repeat (3) @(negedge rd_clk);
    endtask

    task automatic push(input logic [DW-1:0] d);
        @(negedge wr_clk);
        wr_en_n = 1'b0;
        wr_data = d;
        @(negedge wr_clk);
        wr_en_n = 1'b1;
    endtask

    task automatic wait_flag(output int n);
        n = 0;
        @(negedge rd_clk);
        while (!rd_flag && n < 10) begin
            @(negedge rd_clk);
            n++;
        end
    endtask

    task automatic pop_req(input logic [DW-1:0] exp, input string req);
        int n;
        wait_flag(n);
        chk({req, " flag before read"}, 32'(rd_flag), 32'd1);
        rd_en_n = 1'b0;
        @(negedge rd_clk);
        rd_en_n = 1'b1;
        chk({req, " data"}, 32'(q), 32'(exp));
    endtask

    task automatic take_fall(input logic [DW-1:0] exp, input string req);
        int n;
        wait_flag(n);
        chk({req, " valid"}, 32'(rd_flag), 32'd1);
        chk({req, " data"}, 32'(q), 32'(exp));
        rd_en_n = 1'b0;
        @(negedge rd_clk);
        rd_en_n = 1'b1;
    endtask

    // R2 and R1: reset state and request-mode basics
    task automatic t_request_mode();
        int n;
        do_reset(3'b010);
        chk("R2 q zero", 32'(q), 32'd0);
        chk("R2 flag low", 32'(rd_flag), 32'd0);
        chk("R2 full low", 32'(wr_full), 32'd0);
        push(word_of(1));
        wait_flag(n);
        // counted from the write's trailing half cycle, so one edge of slack
        chk("R5 flag latency", 32'(n <= 5), 32'd1);
        chk("R6 q untouched by write", 32'(q), 32'd0);
        push(word_of(2));
        push(word_of(3));
        repeat (6) @(negedge rd_clk);
        pop_req(word_of(1), "R4 R6");
        pop_req(word_of(2), "R4 R6");
        pop_req(word_of(3), "R4 R6");
        chk("R5 flag drops on last read", 32'(rd_flag), 32'd0);
        rd_en_n = 1'b0;
        repeat (3) @(negedge rd_clk);
        rd_en_n = 1'b1;
        chk("R7 q holds on empty read", 32'(q), 32'(word_of(3)));
        chk("R7 flag stays low", 32'(rd_flag), 32'd0);
    endtask

    // R3 and R11: fill, overflow attempts, drain
    task automatic t_full();
        do_reset(3'b010);
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge wr_clk);
            wr_en_n = 1'b0;
            wr_data = word_of(100 + i);
        end
        @(negedge wr_clk);
        wr_en_n = 1'b1;
        chk("R3 full after DEPTH writes", 32'(wr_full), 32'd1);
        for (int i = 0; i < 3; i++) push(18'h3FFFF);
        chk("R3 full holds", 32'(wr_full), 32'd1);
        for (int i = 0; i < DEPTH; i++) pop_req(word_of(100 + i), "R3 R4 order");
        repeat (8) @(negedge rd_clk);
        chk("R11 refused words absent", 32'(rd_flag), 32'd0);
        repeat (6) @(negedge wr_clk);
        chk("R11 full clears", 32'(wr_full), 32'd0);
    endtask

    // R8, R9, R10 and R1: fall-through mode
    task automatic t_fall_mode();
        int n;
        do_reset(3'b101);
        mode_cfg = 3'b010;  // changes after reset must not matter (R1)
        chk("R2 q zero fall", 32'(q), 32'd0);
        chk("R2 flag low fall", 32'(rd_flag), 32'd0);
        push(word_of(7));
        wait_flag(n);
        chk("R8 first word latency", 32'(n <= 6), 32'd1);
        chk("R8 first word on q", 32'(q), 32'(word_of(7)));
        chk("R1 held fall mode", 32'(rd_flag), 32'd1);
        push(word_of(8));
        push(word_of(9));
        repeat (6) @(negedge rd_clk);
        take_fall(word_of(7), "R9");
        take_fall(word_of(8), "R9");
        take_fall(word_of(9), "R9");
        chk("R9 valid drops", 32'(rd_flag), 32'd0);
        chk("R9 last word held", 32'(q), 32'(word_of(9)));
        rd_en_n = 1'b0;
        repeat (3) @(negedge rd_clk);
        rd_en_n = 1'b1;
        chk("R10 q holds", 32'(q), 32'(word_of(9)));
        chk("R10 flag low", 32'(rd_flag), 32'd0);
    endtask

    // R1: undefined encodings fall back to request mode
    task automatic t_default_mode(input logic [2:0] cfg);
        int n;
        do_reset(cfg);
        push(word_of(50));
        wait_flag(n);
        chk("R1 flag up", 32'(rd_flag), 32'd1);
        repeat (4) @(negedge rd_clk);
        chk("R1 no fall-through", 32'(q), 32'd0);
        pop_req(word_of(50), "R1 request read");
    endtask

    initial begin
        repeat (150000) @(posedge wr_clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_request_mode();
        t_full();
        t_fall_mode();
        t_default_mode(3'b011);
        t_default_mode(3'b100);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule